// File: doc/BRIEF.md
# DDR3 Read Command Spacer

This block stands in front of the command issue path of a DDR3 memory controller. It paces back-to-back read commands so that their data bursts never collide on the shared data bus. Each read request arrives with a one-bit burst type: a chopped burst of four beats, or a full burst of eight beats. After a command goes out, the block withholds the next one until the spacing required by the burst just issued has passed.

On the request side the block uses a valid/ready handshake. A chopped burst occupies the bus for two command clocks and must be followed by one idle clock, so a chopped read is followed by a three-clock spacing. A full burst gives a four-clock spacing. The spacing depends only on the previous command and not on the next one. A down-counter is loaded on every issue. The request side is ready whenever that counter is at zero. If no spacing is pending, a waiting request goes out in the cycle it is presented. On the command side the block gives a one-cycle issue strobe and the burst type of the command it issues.

Top module: `rd_cmd_spacer`

## Requirements
- R1: After reset, `req_ready` is 1 and `iss_strobe` is 0. The first request after reset issues in the cycle it is presented.
- R2: `iss_strobe` is 1 in exactly the cycles where `req_valid` and `req_ready` are both 1. In such a cycle `iss_chop` equals `req_chop`, with 1 meaning a chopped (4-beat) burst and 0 meaning a full (8-beat) burst.
- R3: After an issue with `req_chop`=1, `req_ready` is 0 for the next GAP_CHOP-1 cycles (2 by default) and is 1 again GAP_CHOP cycles (3 by default) after the issue.
- R4: After an issue with `req_chop`=0, `req_ready` is 0 for the next GAP_FULL-1 cycles (3 by default) and is 1 again GAP_FULL cycles (4 by default) after the issue.
- R5: The spacing is set by the type of the previous issued command. A full request that follows a chopped one issues 3 cycles later. A chopped request that follows a full one issues 4 cycles later.
- R6: Once the spacing has run out, `req_ready` stays 1 through any idle period. A request presented after the spacing has run out, including exactly at its end, issues in that same cycle.
- R7: A request that is held valid while `req_ready` is 0 does not issue and stays pending. It issues in the first cycle in which the spacing has run out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A read request is offered |
| req_chop | input | 1 | Burst type of the offered request: 1 chopped, 0 full |
| req_ready | output | 1 | The spacing has run out and a request may issue |
| iss_strobe | output | 1 | One-cycle pulse: a read command is issued this cycle |
| iss_chop | output | 1 | Burst type of the issued command |

## Verification
Two things can happen in the same cycle: the spacing counter runs out, and a new command issues and reloads the counter. Holding `req_valid` high over a stream of mixed burst types makes the block issue on the exact cycle of expiry, with every type transition. The scoreboard expects each issue on the cycle computed from the previous type, and checks `req_ready` on every cycle against the same model. A late reload or an extra cycle of dead time shows up as a misplaced strobe or a wrong ready value.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
   typedef enum logic {
      BURST_FULL = 1'b0,
      BURST_CHOP = 1'b1
   } burst_e;

   function automatic int gap_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/rcs_gap_select.sv
module rcs_gap_select #(
   parameter int GAP_CHOP = 3,
   parameter int GAP_FULL = 4,
   parameter int CNT_W    = 3
) (
   input  logic             chop,
   output logic [CNT_W-1:0] load_val
);
   import rcs_pkg::*;

   localparam logic [CNT_W-1:0] LD_CHOP = CNT_W'(GAP_CHOP - 1);
   localparam logic [CNT_W-1:0] LD_FULL = CNT_W'(GAP_FULL - 1);

   generate
      if (GAP_CHOP == GAP_FULL) begin : g_same
         logic unused_chop;
         assign unused_chop = chop;
         assign load_val    = LD_FULL;
      end else begin : g_mux
         always_comb begin
            if (burst_e'(chop) == BURST_CHOP) load_val = LD_CHOP;
            else                              load_val = LD_FULL;
         end
      end
   endgenerate
endmodule

// File: rtl/rcs_gap_counter.sv
module rcs_gap_counter #(
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_en,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
   localparam logic [CNT_W-1:0] ZERO = '0;

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)            cnt_q <= ZERO;
      else if (load_en)      cnt_q <= load_val;
      else if (cnt_q != ZERO) cnt_q <= cnt_q - ONE;
   end

   assign expired = (cnt_q == ZERO);
endmodule

// File: rtl/rcs_issue_gate.sv
module rcs_issue_gate (
   input  logic req_valid,
   input  logic req_chop,
   input  logic expired,
   output logic req_ready,
   output logic fire,
   output logic iss_chop
);
   assign req_ready = expired;
   assign fire      = req_valid & expired;
   assign iss_chop  = req_chop;
endmodule

// File: rtl/rd_cmd_spacer.sv
module rd_cmd_spacer #(
   parameter int GAP_CHOP = 3,
   parameter int GAP_FULL = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_valid,
   input  logic req_chop,
   output logic req_ready,
   output logic iss_strobe,
   output logic iss_chop
);
   import rcs_pkg::*;

   localparam int GAP_MAX = gap_max(GAP_CHOP, GAP_FULL);
   localparam int CNT_W   = $clog2(GAP_MAX + 1);

   generate
      if (GAP_CHOP < 1) begin : g_bad_chop
         $error("GAP_CHOP must be at least 1");
      end
      if (GAP_FULL < 1) begin : g_bad_full
         $error("GAP_FULL must be at least 1");
      end
   endgenerate

   logic             expired;
   logic             fire;
   logic [CNT_W-1:0] load_val;

   rcs_gap_select #(
      .GAP_CHOP(GAP_CHOP),
      .GAP_FULL(GAP_FULL),
      .CNT_W   (CNT_W)
   ) u_sel (
      .chop    (req_chop),
      .load_val(load_val)
   );

   rcs_gap_counter #(
      .CNT_W(CNT_W)
   ) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_en (fire),
      .load_val(load_val),
      .expired (expired)
   );

   rcs_issue_gate u_gate (
      .req_valid(req_valid),
      .req_chop (req_chop),
      .expired  (expired),
      .req_ready(req_ready),
      .fire     (fire),
      .iss_chop (iss_chop)
   );

   assign iss_strobe = fire;
endmodule

// File: rtl/rcs_checker.sv
module rcs_checker #(
   parameter int GAP_CHOP = 3,
   parameter int GAP_FULL = 4
) (
   input logic clk,
   input logic rst_n,
   input logic req_valid,
   input logic req_chop,
   input logic req_ready,
   input logic iss_strobe,
   input logic iss_chop
);
   localparam int GAP_MAX = (GAP_CHOP > GAP_FULL) ? GAP_CHOP : GAP_FULL;

   logic        seen_q;
   logic        last_chop_q;
   int unsigned since_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seen_q      <= 1'b0;
         last_chop_q <= 1'b0;
         since_q     <= 0;
      end else if (iss_strobe) begin
         seen_q      <= 1'b1;
         last_chop_q <= iss_chop;
         since_q     <= 1;
      end else if (since_q < GAP_MAX) begin
         since_q     <= since_q + 1;
      end
   end

   assert_reset_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !seen_q |-> req_ready);

   assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |-> !iss_strobe);

   assert_type_out_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_strobe && req_chop) |-> iss_chop);

   assert_chop_space_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && last_chop_q) |-> (req_ready == (since_q >= GAP_CHOP)));

   assert_full_space_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && !last_chop_q) |-> (req_ready == (since_q >= GAP_FULL)));

   assert_pending_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |-> !iss_strobe);
endmodule

bind rd_cmd_spacer rcs_checker #(
   .GAP_CHOP(GAP_CHOP),
   .GAP_FULL(GAP_FULL)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_chop  (req_chop),
   .req_ready (req_ready),
   .iss_strobe(iss_strobe),
   .iss_chop  (iss_chop)
);

// File: tb/rd_cmd_spacer_tb.sv
`timescale 1ns/1ps
module rd_cmd_spacer_tb;
   localparam int GAP_CHOP = 3;
   localparam int GAP_FULL = 4;

   typedef struct {
      bit          chop;
      int unsigned cyc;
      string       tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic req_chop = 1'b0;
   logic req_ready;
   logic iss_strobe;
   logic iss_chop;

   int unsigned cyc = 0;
   int unsigned drv_next = 0;
   int unsigned mon_next = 0;
   int          mon_last = -1;
   int          n_checks = 0;
   int          n_errors = 0;
   bit          done = 1'b0;
   bit          mon_on = 1'b0;
   exp_t        sb[$];

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   rd_cmd_spacer #(
      .GAP_CHOP(GAP_CHOP),
      .GAP_FULL(GAP_FULL)
   ) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_chop  (req_chop),
      .req_ready (req_ready),
      .iss_strobe(iss_strobe),
      .iss_chop  (iss_chop)
   );

   function automatic int unsigned gap_of(input bit c);
      return c ? GAP_CHOP : GAP_FULL;
   endfunction

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d at cycle %0d",
                  tag, what, act, exp, cyc);
      end
   endtask

   // driver: present a request and hold it until it issues
   task automatic send(input bit c, input string tag);
      exp_t e;
      @(negedge clk);
      req_valid = 1'b1;
      req_chop  = c;
      e.chop = c;
      e.cyc  = (cyc > drv_next) ? cyc : drv_next;
      e.tag  = tag;
      sb.push_back(e);
      drv_next = e.cyc + gap_of(c);
      forever begin
         #1;
         if (req_ready) break;
         @(negedge clk);
      end
   endtask

   task automatic idle(input int n);
      @(negedge clk);
      req_valid = 1'b0;
      for (int i = 1; i < n; i++) @(negedge clk);
   endtask

   // monitor: compare ready every cycle and each strobe against the queue
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (mon_on) begin
            string rtag;
            rtag = (mon_last < 0) ? "R1" : (mon_last == 1 ? "R3" : "R4");
            check(req_ready == (cyc >= mon_next), rtag, "req_ready",
                  req_ready, (cyc >= mon_next));
            if (iss_strobe) begin
               if (sb.size() == 0) begin
                  check(1'b0, "R2", "unexpected strobe", 1, 0);
               end else begin
                  exp_t e;
                  e = sb.pop_front();
                  check(cyc == e.cyc, e.tag, "issue cycle", cyc, e.cyc);
                  check(iss_chop == e.chop, "R2", "iss_chop", iss_chop, e.chop);
                  mon_next = cyc + gap_of(e.chop);
                  mon_last = e.chop;
               end
            end else if (sb.size() != 0 && sb[0].cyc == cyc) begin
               check(1'b0, sb[0].tag, "missed strobe", 0, 1);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      check(req_ready == 1'b1, "R1", "ready in reset", req_ready, 1);
      check(iss_strobe == 1'b0, "R1", "strobe in reset", iss_strobe, 0);
      @(negedge clk);
      rst_n = 1'b1;
      drv_next = cyc;
      mon_next = cyc;
      mon_on = 1'b1;
      #1;
      check(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);

      // R1: first request goes out at once
      send(1'b1, "R1");
      // R3: chopped back to back
      send(1'b1, "R3");
      send(1'b1, "R3");
      // R5: full after chopped, chopped after full
      send(1'b0, "R5");
      send(1'b1, "R5");
      // R4: full back to back
      send(1'b0, "R4");
      send(1'b0, "R4");
      send(1'b0, "R4");
      // R6: long idle, then immediate issue
      idle(8);
      send(1'b1, "R6");
      // R6: arrival exactly at the end of a chopped spacing
      idle(2);
      send(1'b0, "R6");
      // R7: arrival while spacing is pending after a full burst
      idle(1);
      send(1'b1, "R7");
      idle(1);
      send(1'b0, "R7");
      idle(6);

      check(sb.size() == 0, "R2", "queue drained", sb.size(), 0);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule